// File: doc/BRIEF.md
# Single-Line Bus Master Slot Engine

This block drives a single-wire, open-collector style device bus as its master. Each accepted command produces one of three timed bus operations: a long reset pulse followed by a presence check, a write slot that sends one bit, or a read slot that takes one bit from a device. All timing is counted in whole microseconds. A prescaler that divides the system clock by `CLK_HZ / 1_000_000` produces the microsecond tick. The block does no byte framing, addressing or error checking. The controller above it issues one command per bit.

The pad is seen as an output enable and an output value, plus a raw input that is brought through a two-stage synchroniser before it is used. A device pulls the line low only while the master has released it, so the same ports suit open-drain and push-pull pads. After any operation completes, the master drives the line high to feed devices that draw their power from the bus. Before the first operation the line is released. A result port returns one bit when a reset or read operation finishes.

Top module: `owm_slot_engine`

## Requirements
- R1: After reset, `cmd_ready` is 1, `bus_oe` is 0 (line released) and `res_valid` is 0.
- R2: A reset operation drives the line low (`bus_oe`=1, `bus_out`=0) for 500 µs, starting the cycle after the command is accepted.
- R3: After the reset low phase, the line is released, and the synchronised input is sampled every 5 µs at release offsets 5, 10, …, 240 µs. The reset result is 1 (device present) if any sample was low, else 0. Sampling stops at the first low.
- R4: A reset operation keeps `cmd_ready` low for 950 µs in total: 500 µs low and then 450 µs released. No command is accepted in that time.
- R5: When any operation completes, the line is driven high (`bus_oe`=1, `bus_out`=1) and stays so until the next command.
- R6: A write-1 operation (opcode 2'b10) drives the line low for 2 µs and then drives it high for 62 µs. It never releases the line.
- R7: A write-0 operation (opcode 2'b01) drives the line low for 62 µs and then drives it high for 2 µs. Both write operations last 64 µs and produce no result.
- R8: A read operation (opcode 2'b11) drives the line low for 2 µs and then releases it. The operation lasts a fixed 64 µs however early a low is seen.
- R9: A read samples at slot offsets 7, 12, …, 47 µs (every 5 µs after release, up to 45 µs after release). It returns 0 if any sample was low and 1 otherwise.
- R10: Opcode 2'b00 selects a reset operation. A command is accepted on a rising clock edge where `cmd_valid` and `cmd_ready` are both 1.
- R11: One microsecond equals `CLK_HZ / 1_000_000` clock cycles. Every phase length is an exact multiple of that count.
- R12: `res_valid` pulses for exactly one cycle. The pulse falls in the first cycle in which `cmd_ready` is high again after a reset or read operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command request |
| cmd_op | input | 2 | Opcode: 00 reset, 01 write 0, 10 write 1, 11 read |
| cmd_ready | output | 1 | High when idle and able to accept a command |
| res_valid | output | 1 | One-cycle strobe carrying a reset or read result |
| res_bit | output | 1 | Presence flag (reset) or received bit (read) |
| bus_oe | output | 1 | Pad output enable |
| bus_out | output | 1 | Pad output value while enabled |
| bus_in | input | 1 | Raw line level from the pad |

## Verification
The embedded assertions check on every cycle:
- that the result strobe is a single cycle and coincides with the return of ready;
- that every accepted command starts with the line driven low;
- that a write slot never releases the line;
- that the line is parked high whenever ready rises;
- that the microsecond tick never fires on two cycles in a row.

Only the bench scenarios can show the phase lengths in cycles, the total busy time and the sampling grid. To do so, the bench models a device that pulls the line low over chosen windows: right at the first and last sample point, just after the window closes, and not at all. It then compares the presence flag and the read bit with values it computes itself.

// File: rtl/owm_pkg.sv
package owm_pkg;
    typedef enum logic [1:0] {
        OP_RESET = 2'b00,
        OP_WR0   = 2'b01,
        OP_WR1   = 2'b10,
        OP_READ  = 2'b11
    } owm_op_e;
endpackage

// File: rtl/owm_us_tick.sv
// Microsecond prescaler, restarted at the start of every operation
module owm_us_tick #(
    parameter int DIV = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic en,
    output logic tick
);
    localparam int CNT_W = (DIV > 1) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt_d, cnt_q;
    logic             wrap;

    assign wrap = (cnt_q == CNT_W'(DIV - 1));
    assign tick = en && wrap;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)       cnt_d = '0;
        else if (tick) cnt_d = '0;
        else if (en)   cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        ((DIV > 1) && tick) |=> !tick); // R11
endmodule

// File: rtl/owm_sync.sv
// Input synchroniser; resets to the idle (high) line level
module owm_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh_d, sh_q;

    assign sh_d = {sh_q[STAGES-2:0], d};
    assign q    = sh_q[STAGES-1];

    always_ff @(posedge clk) begin
        if (!rst_n) sh_q <= '1;
        else        sh_q <= sh_d;
    end
endmodule

// File: rtl/owm_slot_table.sv
// Per-operation phase lengths, in microseconds from operation start
module owm_slot_table
    import owm_pkg::*;
#(
    parameter int US_W        = 10,
    parameter int RST_LOW_US  = 500,
    parameter int RST_REC_US  = 450,
    parameter int PRES_WIN_US = 240,
    parameter int SLOT_US     = 64,
    parameter int SHORT_US    = 2,
    parameter int RD_WIN_US   = 45
) (
    input  owm_op_e         op,
    output logic [US_W-1:0] low_len,
    output logic [US_W-1:0] total_len,
    output logic [US_W-1:0] win_end,
    output logic            releases,
    output logic            has_result
);
    always_comb begin
        total_len  = US_W'(SLOT_US);
        win_end    = '0;
        releases   = 1'b0;
        has_result = 1'b0;
        unique case (op)
            OP_RESET: begin
                low_len    = US_W'(RST_LOW_US);
                total_len  = US_W'(RST_LOW_US + RST_REC_US);
                win_end    = US_W'(RST_LOW_US + PRES_WIN_US);
                releases   = 1'b1;
                has_result = 1'b1;
            end
            OP_WR0:  low_len = US_W'(SLOT_US - SHORT_US);
            OP_WR1:  low_len = US_W'(SHORT_US);
            default: begin
                low_len    = US_W'(SHORT_US);
                win_end    = US_W'(SHORT_US + RD_WIN_US);
                releases   = 1'b1;
                has_result = 1'b1;
            end
        endcase
    end
endmodule

// File: rtl/owm_slot_engine.sv
module owm_slot_engine
    import owm_pkg::*;
#(
    parameter int CLK_HZ      = 50_000_000,
    parameter int RST_LOW_US  = 500,
    parameter int RST_REC_US  = 450,
    parameter int PRES_WIN_US = 240,
    parameter int SLOT_US     = 64,
    parameter int SHORT_US    = 2,
    parameter int RD_WIN_US   = 45,
    parameter int POLL_US     = 5
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [1:0] cmd_op,
    output logic       cmd_ready,
    output logic       res_valid,
    output logic       res_bit,
    output logic       bus_oe,
    output logic       bus_out,
    input  logic       bus_in
);
    localparam int DIV    = CLK_HZ / 1_000_000;
    localparam int US_W   = $clog2(RST_LOW_US + RST_REC_US + 1);
    localparam int POLL_W = (POLL_US > 1) ? $clog2(POLL_US) : 1;

    typedef struct packed {
        logic              busy;
        owm_op_e           op;
        logic [US_W-1:0]   us;
        logic [POLL_W-1:0] poll;
        logic              seen;
        logic              park;
        logic              rv;
        logic              rbit;
    } eng_t;

    eng_t st_d, st_q;

    logic            tick, line_s, accept, in_rel;
    logic [US_W-1:0] low_len, total_len, win_end, us_inc;
    logic            releases, has_result;

    owm_us_tick #(.DIV(DIV)) tick_i (
        .clk(clk), .rst_n(rst_n), .clr(accept), .en(st_q.busy), .tick(tick)
    );

    owm_sync #(.STAGES(2)) sync_i (
        .clk(clk), .rst_n(rst_n), .d(bus_in), .q(line_s)
    );

    owm_slot_table #(
        .US_W(US_W), .RST_LOW_US(RST_LOW_US), .RST_REC_US(RST_REC_US),
        .PRES_WIN_US(PRES_WIN_US), .SLOT_US(SLOT_US), .SHORT_US(SHORT_US),
        .RD_WIN_US(RD_WIN_US)
    ) table_i (
        .op(st_q.op), .low_len(low_len), .total_len(total_len), .win_end(win_end),
        .releases(releases), .has_result(has_result)
    );

    assign accept = cmd_valid && !st_q.busy;
    assign us_inc = st_q.us + 1'b1;
    assign in_rel = releases && (st_q.us >= low_len);

    always_comb begin
        st_d    = st_q;
        st_d.rv = 1'b0;
        if (accept) begin
            st_d.busy = 1'b1;
            st_d.op   = owm_op_e'(cmd_op);
            st_d.us   = '0;
            st_d.poll = '0;
            st_d.seen = 1'b0;
        end else if (st_q.busy && tick) begin
            st_d.us = us_inc;
            if (in_rel) begin
                if (st_q.poll == POLL_W'(POLL_US - 1)) begin
                    st_d.poll = '0;
                    if (!st_q.seen && (us_inc <= win_end) && !line_s) st_d.seen = 1'b1;
                end else begin
                    st_d.poll = st_q.poll + 1'b1;
                end
            end
            if (us_inc == total_len) begin
                st_d.busy = 1'b0;
                st_d.park = 1'b1;
                st_d.rv   = has_result;
                st_d.rbit = (st_q.op == OP_RESET) ? st_d.seen : !st_d.seen;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.op   <= OP_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        bus_out = 1'b1;
        bus_oe  = st_q.park;
        if (st_q.busy) begin
            if (st_q.us < low_len) begin
                bus_oe  = 1'b1;
                bus_out = 1'b0;
            end else begin
                bus_oe = !releases;
            end
        end
    end

    assign cmd_ready = !st_q.busy;
    assign res_valid = st_q.rv;
    assign res_bit   = st_q.rbit;

    AST_RES_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R12
    AST_RES_AT_READY: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> cmd_ready); // R12
    AST_START_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> (bus_oe && !bus_out)); // R2
    AST_WRITE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_ready && (st_q.op == OP_WR0 || st_q.op == OP_WR1)) |-> bus_oe); // R6
    AST_PARK_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_ready) |-> (bus_oe && bus_out)); // R5
    AST_NO_WRITE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (st_q.op == OP_RESET || st_q.op == OP_READ)); // R7
endmodule

// File: tb/owm_slot_engine_tb.sv
module owm_slot_engine_tb_top;
    localparam int DIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic       cmd_ready, res_valid, res_bit, bus_oe, bus_out, bus_in;

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    int base = 0;
    bit active = 1'b0;
    int dev_rel = 0, dev_s = 1000, dev_e = 1000;
    logic dev_low;

    always #2 clk = ~clk; // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    assign dev_low = active && (((cyc - base) / DIV) >= dev_rel + dev_s)
                            && (((cyc - base) / DIV) <  dev_rel + dev_e);
    assign bus_in  = bus_oe ? bus_out : ~dev_low;

    owm_slot_engine #(.CLK_HZ(DIV * 1_000_000)) dut_i (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_ready(cmd_ready), .res_valid(res_valid), .res_bit(res_bit),
        .bus_oe(bus_oe), .bus_out(bus_out), .bus_in(bus_in)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_low(input logic [1:0] op);
        case (op)
            2'b00:   return 500;
            2'b01:   return 62;
            default: return 2;
        endcase
    endfunction

    function automatic int exp_total(input logic [1:0] op);
        return (op == 2'b00) ? 950 : 64;
    endfunction

    // Device low over [ds, de) microseconds after release; samples every 5 us
    function automatic bit exp_seen(input logic [1:0] op, input int ds, input int de);
        int n = (op == 2'b00) ? 48 : 9;
        bit s = 1'b0;
        for (int j = 1; j <= n; j++)
            if (5 * j >= ds && 5 * j < de) s = 1'b1;
        return s;
    endfunction

    task automatic run_op(input logic [1:0] op, input int ds, input int de);
        int lowc = 0, relc = 0, hic = 0, busyc = 0, rvc = 0;
        logic gv, gb;
        bit rel_op = (op == 2'b00 || op == 2'b11);
        string rq_low = (op == 2'b00) ? "R2" : (op == 2'b01) ? "R7" : (op == 2'b10) ? "R6" : "R8";
        string rq_tot = (op == 2'b00) ? "R4" : (op == 2'b11) ? "R8" : "R7";
        @(negedge clk);
        check(cmd_ready === 1'b1, "R10", "ready before issue", int'(cmd_ready), 1);
        dev_rel = exp_low(op);
        dev_s = ds;
        dev_e = de;
        cmd_op = op;
        cmd_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        base = cyc;
        active = 1'b1;
        cmd_valid = 1'b0;
        while (cmd_ready !== 1'b1 && busyc < 20000) begin
            if (bus_oe && !bus_out) lowc++;
            else if (!bus_oe) relc++;
            else hic++;
            if (res_valid) rvc++;
            busyc++;
            @(negedge clk);
        end
        gv = res_valid;
        gb = res_bit;
        active = 1'b0;
        check(lowc == exp_low(op) * DIV, rq_low, "low cycles", lowc, exp_low(op) * DIV);
        check(busyc == exp_total(op) * DIV, rq_tot, "busy cycles", busyc, exp_total(op) * DIV);
        if (rel_op) begin
            check(relc == (exp_total(op) - exp_low(op)) * DIV, rq_tot, "released cycles",
                  relc, (exp_total(op) - exp_low(op)) * DIV);
        end else begin
            check(hic == (exp_total(op) - exp_low(op)) * DIV, rq_low, "driven-high cycles",
                  hic, (exp_total(op) - exp_low(op)) * DIV);
        end
        check(rvc == 0, "R12", "result strobe while busy", rvc, 0);
        if (op == 2'b00) begin
            check(gv === 1'b1, "R4", "reset result valid", int'(gv), 1);
            check(gb === exp_seen(op, ds, de), "R3", "presence flag", int'(gb), int'(exp_seen(op, ds, de)));
        end else if (op == 2'b11) begin
            check(gv === 1'b1, "R8", "read result valid", int'(gv), 1);
            check(gb === !exp_seen(op, ds, de), "R9", "read bit", int'(gb), int'(!exp_seen(op, ds, de)));
        end else begin
            check(gv === 1'b0, "R7", "no result for write", int'(gv), 0);
        end
        check(bus_oe && bus_out, "R5", "line parked high", int'({bus_oe, bus_out}), 3);
        @(negedge clk);
        check(res_valid === 1'b0, "R12", "strobe one cycle", int'(res_valid), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        repeat (3) @(posedge clk);
        @(negedge clk);
        check(cmd_ready === 1'b1, "R1", "ready in reset", int'(cmd_ready), 1);
        check(bus_oe === 1'b0, "R1", "line released in reset", int'(bus_oe), 0);
        check(res_valid === 1'b0, "R1", "no result in reset", int'(res_valid), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(bus_oe === 1'b0 && cmd_ready === 1'b1, "R1", "idle before first op",
              int'({bus_oe, cmd_ready}), 1);
        // Directed corner cases
        run_op(2'b00, 1000, 1000);   // R3 no device
        run_op(2'b00, 2, 8);         // R3 low only at first sample
        run_op(2'b00, 237, 243);     // R3 low only at the last sample (240)
        run_op(2'b00, 242, 263);     // R3 low only after the window
        run_op(2'b10, 1000, 1000);   // R6
        run_op(2'b01, 1000, 1000);   // R7
        run_op(2'b11, 1000, 1000);   // R9 reads 1
        run_op(2'b11, 2, 8);         // R9 low at first sample
        run_op(2'b11, 42, 48);       // R9 low only at last sample (47)
        run_op(2'b11, 47, 63);       // R9 low after window: reads 1
        // Random mix
        for (int i = 0; i < 24; i++) begin
            logic [1:0] op = 2'($urandom_range(0, 3));
            int a = (op == 2'b00) ? $urandom_range(0, 55) : $urandom_range(0, 12);
            int b = $urandom_range(0, 3);
            if (op == 2'b00 && i % 3 != 0) op = 2'b11;
            run_op(op, 5 * a + 2, 5 * (a + b) + 3);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule